// File: doc/BRIEF.md
# Profile-Hopping DDS Phase Accumulator

This block is the phase engine of a direct digital synthesiser. A 32-bit frequency word is added into a 32-bit phase register on every clock. The top 14 bits of that register go out on every cycle as the address for a phase-to-amplitude stage that lies outside this block. Four frequency words are held in profile registers. A 2-bit select input picks the live profile, so the output can hop between four frequencies with no register write.

A 2-bit mode input picks one of three behaviours. Single tone runs at the selected profile word. Sweep starts from the selected profile word and raises it by a programmed step after each programmed number of clocks, stopping at a programmed ceiling. Sleep freezes the phase register and drives the output to zero. A change of word never clears the phase register: the next phase is the old phase plus the new word. The output phase therefore stays continuous across every hop, sweep step and wake-up.

Top module: `dds_phase_engine`

## Requirements
- R1: After reset the phase register, all profile words, the sweep step, interval and ceiling are zero, and `phaseOut` reads 0.
- R2: In a running mode the phase register gains the active word on every rising edge, modulo 2^32, and `phaseOut` shows bits 31..18 of it.
- R3: `selIn` is captured on a rising edge, and the captured value picks profile register 0..3 (write addresses 0..3). The first addition with the new word happens on the following edge.
- R4: Changing the active word never resets the phase register. The first phase after a change equals the last phase before it plus the new word.
- R5: Mode codes 2'b10 and 2'b11 (sleep), captured on an edge, hold the phase register and force `phaseOut` to 0. On leaving sleep, accumulation resumes from the held value.
- R6: Mode 2'b01 (sweep) starts from the profile word selected on entry. After every N edges spent in sweep, that word grows by the step (address 4). N is the interval at address 5, bits 15..0, and 0 counts as 1.
- R7: A sweep step whose unsigned result would pass the ceiling (address 6) loads the ceiling instead, and the sweep then stays there.
- R8: A write with `wrEn` high loads `wrData` into the register at `wrAddr` on the rising edge, and the new value is used from the next edge on. Address 7 is ignored.
- R9: Mode 2'b00 (single tone) runs at the captured profile word with no automatic change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address: 0-3 profiles, 4 step, 5 interval, 6 ceiling |
| wrData | input | 32 | Write data |
| modeIn | input | 2 | 00 tone, 01 sweep, 1x sleep |
| selIn | input | 2 | Profile select |
| phaseOut | output | 14 | Truncated phase address |

## Verification
The bench runs four profile words. One advances the output by exactly one code per clock, and one wraps backwards past zero. Together they separate a correct modulo add and a correct 14-bit slice from off-by-one slicing or from saturation. Fast alternating hops check that the phase carries on with no reset and that the select takes effect exactly one edge late. A short sweep with a small ceiling shows whether the step timing, the zero-interval rule and the clamp are right. Sleep with both codes, a write to the unused address, and resuming afterwards show that the held phase is kept and that the ignored write changes nothing.

// File: rtl/dds_pkg.sv
package dds_pkg;

  typedef enum logic [1:0] {
    MODE_TONE      = 2'b00,
    MODE_SWEEP     = 2'b01,
    MODE_SLEEP     = 2'b10,
    MODE_SLEEP_ALT = 2'b11
  } ddsMode_e;

  // strobes sent from control to datapath each cycle
  typedef struct packed {
    logic accEn;      // add the active word into the phase register
    logic sweepLoad;  // not sweeping: sweep word follows selected profile
    logic sweepStep;  // sweeping: apply one clamped step this edge
    logic forceZero;  // drive the phase output to zero
  } ddsStrobe_t;

endpackage

// File: rtl/dds_ctrl.sv
module dds_ctrl
  import dds_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeIn,
  input  logic [SEL_W-1:0] selIn,
  input  logic [CNT_W-1:0] intervalVal,
  output logic [SEL_W-1:0] selReg,
  output ddsStrobe_t       strb
);

  ddsMode_e         modeReg;
  logic [CNT_W-1:0] dwellCnt;
  logic [CNT_W-1:0] intervalEff;
  logic             inSweep;
  logic             inSleep;

  assign intervalEff = (intervalVal == '0) ? CNT_W'(1) : intervalVal;
  assign inSweep     = (modeReg == MODE_SWEEP);
  assign inSleep     = modeReg[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= MODE_TONE;
      selReg  <= '0;
    end else begin
      modeReg <= ddsMode_e'(modeIn);
      selReg  <= selIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dwellCnt <= '0;
    end else if (!inSweep || strb.sweepStep) begin
      dwellCnt <= '0;
    end else begin
      dwellCnt <= dwellCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strb.accEn     = !inSleep;
    strb.forceZero = inSleep;
    strb.sweepLoad = !inSweep;
    strb.sweepStep = inSweep && (dwellCnt >= intervalEff - CNT_W'(1));
  end

  // R6: a step and a reload are never asked for together
  assert_step_load_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.sweepLoad, strb.sweepStep}));

  // R6: the dwell count starts over after every step
  assert_dwell_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.sweepStep |=> (dwellCnt == '0));

endmodule

// File: rtl/dds_datapath.sv
module dds_datapath
  import dds_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 14,
  parameter int NPROF  = 4,
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ACC_W-1:0]  wrData,
  input  logic [SEL_W-1:0]  selReg,
  input  ddsStrobe_t        strb,
  output logic [CNT_W-1:0]  intervalVal,
  output logic [OUT_W-1:0]  phaseOut
);

  localparam logic [ADDR_W-1:0] ADDR_STEP     = ADDR_W'(NPROF);
  localparam logic [ADDR_W-1:0] ADDR_INTERVAL = ADDR_W'(NPROF + 1);
  localparam logic [ADDR_W-1:0] ADDR_CEIL     = ADDR_W'(NPROF + 2);

  logic [ACC_W-1:0] profReg [NPROF];
  logic [ACC_W-1:0] stepReg;
  logic [ACC_W-1:0] ceilReg;
  logic [CNT_W-1:0] intervalReg;
  logic [ACC_W-1:0] sweepWord;
  logic [ACC_W-1:0] phaseAcc;
  logic [ACC_W-1:0] activeWord;
  logic [ACC_W:0]   stepSum;
  logic [ACC_W-1:0] stepNext;
  logic             ceilWrite;

  genvar gp;
  generate
    for (gp = 0; gp < NPROF; gp++) begin : g_prof
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) profReg[gp] <= '0;
        else if (wrEn && wrAddr == ADDR_W'(gp)) profReg[gp] <= wrData;
      end
    end
  endgenerate

  assign ceilWrite = wrEn && (wrAddr == ADDR_CEIL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepReg     <= '0;
      ceilReg     <= '0;
      intervalReg <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_STEP)     stepReg     <= wrData;
      if (wrAddr == ADDR_INTERVAL) intervalReg <= wrData[CNT_W-1:0];
      if (ceilWrite)               ceilReg     <= wrData;
    end
  end

  assign intervalVal = intervalReg;

  // clamped sweep increment
  assign stepSum  = {1'b0, sweepWord} + {1'b0, stepReg};
  assign stepNext = (stepSum > {1'b0, ceilReg}) ? ceilReg : stepSum[ACC_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sweepWord <= '0;
    else if (strb.sweepLoad) sweepWord <= profReg[selReg];
    else if (strb.sweepStep) sweepWord <= stepNext;
  end

  assign activeWord = strb.sweepLoad ? profReg[selReg] : sweepWord;

  // phase register: never cleared by a word change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           phaseAcc <= '0;
    else if (strb.accEn) phaseAcc <= phaseAcc + activeWord;
  end

  assign phaseOut = strb.forceZero ? '0 : phaseAcc[ACC_W-1 -: OUT_W];

  // R5: sleeping leaves the phase register untouched
  assert_sleep_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accEn |=> $stable(phaseAcc));

  // R7: after a step the sweep word is at or below the ceiling
  assert_ceiling_clamp_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sweepStep && !ceilWrite) |=> (sweepWord <= ceilReg));

endmodule

// File: rtl/dds_phase_engine.sv
module dds_phase_engine
  import dds_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 14,
  parameter int NPROF  = 4,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ACC_W-1:0]  wrData,
  input  logic [1:0]        modeIn,
  input  logic [$clog2(NPROF)-1:0] selIn,
  output logic [OUT_W-1:0]  phaseOut
);

  localparam int SEL_W = $clog2(NPROF);

  logic [SEL_W-1:0] selReg;
  logic [CNT_W-1:0] intervalVal;
  ddsStrobe_t       strb;

  dds_ctrl #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .selIn(selIn),
    .intervalVal(intervalVal), .selReg(selReg), .strb(strb)
  );

  dds_datapath #(.ACC_W(ACC_W), .OUT_W(OUT_W), .NPROF(NPROF), .SEL_W(SEL_W),
                 .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .selReg(selReg), .strb(strb), .intervalVal(intervalVal), .phaseOut(phaseOut)
  );

endmodule

// File: tb/dds_phase_engine_bench.sv
`timescale 1ns/1ps
module dds_phase_engine_bench;

  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0;
  logic [2:0]  wrAddr = 0;
  logic [31:0] wrData = 0;
  logic [1:0]  modeIn = 0;
  logic [1:0]  selIn = 0;
  logic [13:0] phaseOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dds_phase_engine u_dds_phase_engine (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .modeIn(modeIn), .selIn(selIn), .phaseOut(phaseOut)
  );

  // reference model state
  logic [31:0] mAcc = 0, mStep = 0, mCeil = 0, mSweep = 0;
  logic [31:0] mProf [4] = '{default: 0};
  int          mIvl = 0, mCnt = 0;
  logic [1:0]  mSel = 0, mMode = 0;

  logic [13:0] expQ[$];
  string       tagQ[$];

  // monitor: compare one result per cycle, away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [13:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      total++;
      if (phaseOut !== e) begin
        bad++;
        $display("FAIL %s: phaseOut=%h expected=%h", t, phaseOut, e);
      end
    end
  end

  // driver: one edge with the inputs currently applied, model advanced
  task automatic tick(input string tag);
    logic [32:0] s;
    logic [31:0] w;
    int ie;
    @(posedge clk);
    w = (mMode == 2'b01) ? mSweep : mProf[mSel];
    if (!mMode[1]) mAcc = mAcc + w;
    if (mMode == 2'b01) begin
      ie = (mIvl == 0) ? 1 : mIvl;
      if (mCnt >= ie - 1) begin
        mCnt = 0;
        s = {1'b0, mSweep} + {1'b0, mStep};
        mSweep = (s > {1'b0, mCeil}) ? mCeil : s[31:0];
      end else mCnt++;
    end else begin
      mCnt = 0;
      mSweep = mProf[mSel];
    end
    if (wrEn) begin
      if (wrAddr < 4) mProf[wrAddr[1:0]] = wrData;
      else if (wrAddr == 4) mStep = wrData;
      else if (wrAddr == 5) mIvl = int'(wrData[15:0]);
      else if (wrAddr == 6) mCeil = wrData;
    end
    mSel = selIn;
    mMode = modeIn;
    expQ.push_back(mMode[1] ? 14'd0 : mAcc[31:18]);
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic run(input logic [1:0] md, input logic [1:0] sl, input int n, input string tag);
    modeIn = md; selIn = sl;
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    wrEn = 1; wrAddr = a; wrData = d;
    tick(tag);
    wrEn = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (phaseOut !== 14'd0) begin
      bad++;
      $display("FAIL R1: reset phaseOut=%h expected=0000", phaseOut);
    end
    rstN = 1;
    run(2'b00, 2'b00, 3, "R1 idle after reset");
    wr(3'd1, 32'h0004_0000, "R8 write profile1");
    wr(3'd2, 32'h8000_0000, "R8 write profile2");
    wr(3'd3, 32'hFFFC_0000, "R8 write profile3");
    wr(3'd0, 32'h0123_4567, "R8 write profile0");
    run(2'b00, 2'b01, 6, "R2 R9 tone on profile1");
    run(2'b00, 2'b11, 8, "R2 wrap on profile3");
    for (int k = 0; k < 4; k++) begin
      run(2'b00, 2'b00, 1, "R3 R4 hop to profile0");
      run(2'b00, 2'b10, 2, "R3 R4 hop to profile2");
    end
    wr(3'd7, 32'hDEAD_BEEF, "R8 address 7 ignored");
    run(2'b00, 2'b01, 3, "R8 run after ignored write");
    run(2'b10, 2'b01, 4, "R5 sleep code 10");
    run(2'b11, 2'b00, 3, "R5 sleep code 11");
    run(2'b00, 2'b01, 4, "R5 resume from held phase");
    wr(3'd4, 32'h0004_0000, "R8 write step");
    wr(3'd5, 32'h0000_0003, "R8 write interval");
    wr(3'd6, 32'h0020_0000, "R8 write ceiling");
    run(2'b01, 2'b01, 14, "R6 sweep interval 3");
    run(2'b01, 2'b01, 20, "R7 sweep held at ceiling");
    run(2'b00, 2'b01, 2, "R9 back to tone");
    wr(3'd5, 32'h0000_0000, "R6 interval zero");
    run(2'b01, 2'b01, 6, "R6 sweep interval zero acts as 1");
    wr(3'd6, 32'hFFFF_FFFF, "R7 raise ceiling");
    run(2'b01, 2'b01, 4, "R7 sweep after ceiling raised");
    run(2'b00, 2'b00, 3, "R4 tone after sweep");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule